// File: doc/BRIEF.md
# Gated Reload Down-Counter Timer

This block is a general-purpose timeout timer. A 16-bit counter is loaded with a programmable reload value and counts down by one on every tick of a 12-bit prescaler. A tick occurs once every `2*presc_val + 1` clock cycles. When the count reaches zero, the timer either stops or reloads itself and keeps running, depending on the restart mode. In both cases it sets a sticky interrupt flag. A separate enable routes that flag onto the interrupt output.

The timer starts in one of two ways: from an immediate start strobe, or automatically from an end-of-transmission pulse when auto-start is enabled. An immediate stop strobe halts it and leaves the count frozen. Optionally, counting can be gated by one of two external level inputs, so that both the prescaler and the counter advance only while the selected gate is high. All pins are plain control and status levels or single-cycle strobes. No data stream passes through the block, so it has no valid/ready handshake.

Top module: `gated_reload_timer`

## Requirements
- R1: After reset, `running`, `count`, `timer_flag` and `irq` are all 0.
- R2: A start request loads `reload_val` into `count`, sets `running` and restarts the prescaler phase. The change is visible after the clock edge that samples the request. A start while already running restarts from `reload_val`.
- R3: While the timer is running and the gate is open, `count` decreases by exactly 1 every `2*presc_val+1` clocks. The first decrement occurs `2*presc_val+1` edges after the start edge.
- R4: With `auto_restart`=0, the tick that takes `count` from 1 (or from 0 after a zero reload) ends the run. After that tick, `count`=0, `running`=0 and `timer_flag`=1. For reload N>0 this happens N*(2P+1) edges after the start edge; for reload 0, it happens 2P+1 edges after.
- R5: With `auto_restart`=1, the zero-reaching tick loads `reload_val` instead of 0, keeps `running`=1 and sets `timer_flag`.
- R6: `stop_now` clears `running` on the next edge and leaves `count` unchanged. It wins over `start_now`, over an auto-start request and over a tick in the same cycle.
- R7: `tx_end` acts as a start request only when `auto_start_en`=1. When `auto_start_en`=0, it has no effect.
- R8: `gate_sel` encoding: 0 = ungated, 1 = gated by `gate_a`, 2 = gated by `gate_b`, 3 = ungated. While the selected gate is low, neither the prescaler nor `count` advances. The unselected gate pin has no effect.
- R9: `timer_flag` stays set until a cycle with `irq_clr`=1. If the zero-reaching tick and `irq_clr` fall in the same cycle, the flag is set.
- R10: `irq` equals `timer_flag` AND `irq_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reload_val | input | 16 | Value loaded on start and on auto restart |
| presc_val | input | 12 | Prescaler setting P; tick period is 2P+1 clocks |
| auto_restart | input | 1 | Reload and continue on reaching zero |
| auto_start_en | input | 1 | Allow `tx_end` to start the timer |
| gate_sel | input | 2 | Gating source select |
| start_now | input | 1 | Immediate start strobe |
| stop_now | input | 1 | Immediate stop strobe |
| tx_end | input | 1 | End-of-transmission pulse |
| gate_a | input | 1 | First gate level input |
| gate_b | input | 1 | Second gate level input |
| irq_clr | input | 1 | Clears the timer flag |
| irq_en | input | 1 | Routes the flag to `irq` |
| count | output | 16 | Current counter value |
| running | output | 1 | Timer is running |
| timer_flag | output | 1 | Sticky zero-reached flag |
| irq | output | 1 | Masked interrupt request |

## Verification
The properties assume that every input, including the two gate pins, is synchronous to `clk` and steady for a whole cycle. They also assume the prescaler setting does not change in the middle of a run whose tick timing is being judged. The bench drives every input on the falling edge and samples there. It changes `presc_val`, `reload_val` and `gate_sel` only while the timer is stopped. The gate patterns change at most once per cycle, so the number of open edges, and from it the expected count, can be computed arithmetically.

// File: rtl/gtimer_pkg.sv
package gtimer_pkg;
  typedef enum logic [1:0] {
    GATE_OFF     = 2'd0,
    GATE_PIN_A   = 2'd1,
    GATE_PIN_B   = 2'd2,
    GATE_OFF_ALT = 2'd3
  } gate_mode_e;
endpackage

// File: rtl/tmr_gate_mux.sv
module tmr_gate_mux
  import gtimer_pkg::*;
(
  input  logic [1:0] gate_sel,
  input  logic       gate_a,
  input  logic       gate_b,
  output logic       gate_open
);
  gate_mode_e mode;
  assign mode = gate_mode_e'(gate_sel);

  always_comb begin
    case (mode)
      GATE_PIN_A: gate_open = gate_a;
      GATE_PIN_B: gate_open = gate_b;
      default:    gate_open = 1'b1;
    endcase
  end
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PRE_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic [PRE_W-1:0] presc_val,
  output logic             tick
);
  localparam int PW = PRE_W + 1;

  logic [PW-1:0] phase;
  logic [PW-1:0] limit;

  // Period of 2P+1 clocks: phase walks 0 .. 2P.
  assign limit = {presc_val, 1'b0};
  assign tick  = run && (phase >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (restart || tick) begin
      phase <= '0;
    end else if (run) begin
      phase <= phase + PW'(1);
    end
  end
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic             stop_req,
  input  logic             tick,
  input  logic             auto_restart,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] count,
  output logic             running,
  output logic             hit
);
  logic at_end;

  assign at_end = (count <= CNT_W'(1));
  assign hit    = tick && running && !stop_req && !start_req && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      running <= 1'b0;
    end else if (stop_req) begin
      running <= 1'b0;
    end else if (start_req) begin
      running <= 1'b1;
      count   <= reload_val;
    end else if (tick && running) begin
      if (at_end) begin
        count   <= auto_restart ? reload_val : '0;
        running <= auto_restart;
      end else begin
        count   <= count - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/tmr_irq_flag.sv
module tmr_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic clr,
  input  logic en,
  output logic flag,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (hit) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  assign irq = flag & en;
endmodule

// File: rtl/gated_reload_timer.sv
module gated_reload_timer #(
  parameter int CNT_W = 16,
  parameter int PRE_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] reload_val,
  input  logic [PRE_W-1:0] presc_val,
  input  logic             auto_restart,
  input  logic             auto_start_en,
  input  logic [1:0]       gate_sel,
  input  logic             start_now,
  input  logic             stop_now,
  input  logic             tx_end,
  input  logic             gate_a,
  input  logic             gate_b,
  input  logic             irq_clr,
  input  logic             irq_en,
  output logic [CNT_W-1:0] count,
  output logic             running,
  output logic             timer_flag,
  output logic             irq
);
  logic start_req;
  logic go;
  logic gate_open;
  logic tick;
  logic hit;

  assign start_req = start_now | (tx_end & auto_start_en);
  assign go        = start_req & ~stop_now;

  tmr_gate_mux u_gate (
    .gate_sel  (gate_sel),
    .gate_a    (gate_a),
    .gate_b    (gate_b),
    .gate_open (gate_open)
  );

  tmr_prescaler #(.PRE_W(PRE_W)) u_presc (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (go),
    .run       (running & gate_open),
    .presc_val (presc_val),
    .tick      (tick)
  );

  tmr_count_core #(.CNT_W(CNT_W)) u_core (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_req    (start_req),
    .stop_req     (stop_now),
    .tick         (tick),
    .auto_restart (auto_restart),
    .reload_val   (reload_val),
    .count        (count),
    .running      (running),
    .hit          (hit)
  );

  tmr_irq_flag u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .hit   (hit),
    .clr   (irq_clr),
    .en    (irq_en),
    .flag  (timer_flag),
    .irq   (irq)
  );
endmodule

// File: rtl/gated_reload_timer_chk.sv
module gated_reload_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_now,
  input logic             stop_now,
  input logic             tx_end,
  input logic             auto_start_en,
  input logic             auto_restart,
  input logic [1:0]       gate_sel,
  input logic             gate_a,
  input logic [CNT_W-1:0] reload_val,
  input logic             irq_clr,
  input logic [CNT_W-1:0] count,
  input logic             running,
  input logic             timer_flag
);
  logic start_any;
  assign start_any = start_now | (tx_end & auto_start_en);

  AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (start_now && !stop_now) |=> (running && count == $past(reload_val))); // R2

  AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_now |=> (!running && count == $past(count))); // R6

  AST_TX_START: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_end && auto_start_en && !stop_now) |=> running); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !start_any) |=> (!running && $stable(count))); // R7

  AST_GATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (running && gate_sel == 2'd1 && !gate_a && !start_any && !stop_now) |=> $stable(count)); // R8

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !start_any && !stop_now && count > CNT_W'(1))
    |=> (count == $past(count) || count == $past(count) - CNT_W'(1))); // R3

  AST_END_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(running) && !$past(stop_now)) |-> (count == '0 && timer_flag)); // R4

  AST_RESTART_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    (running && auto_restart && !stop_now) |=> running); // R5

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (timer_flag && !irq_clr) |=> timer_flag); // R9
endmodule

bind gated_reload_timer gated_reload_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start_now     (start_now),
  .stop_now      (stop_now),
  .tx_end        (tx_end),
  .auto_start_en (auto_start_en),
  .auto_restart  (auto_restart),
  .gate_sel      (gate_sel),
  .gate_a        (gate_a),
  .reload_val    (reload_val),
  .irq_clr       (irq_clr),
  .count         (count),
  .running       (running),
  .timer_flag    (timer_flag)
);

// File: tb/gated_reload_timer_test.sv
module gated_reload_timer_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] reload_val;
  logic [11:0] presc_val;
  logic        auto_restart, auto_start_en;
  logic [1:0]  gate_sel;
  logic        start_now, stop_now, tx_end, gate_a, gate_b, irq_clr, irq_en;
  logic [15:0] count;
  logic        running, timer_flag, irq;

  int checks   = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gated_reload_timer uut (
    .clk(clk), .rst_n(rst_n), .reload_val(reload_val), .presc_val(presc_val),
    .auto_restart(auto_restart), .auto_start_en(auto_start_en), .gate_sel(gate_sel),
    .start_now(start_now), .stop_now(stop_now), .tx_end(tx_end), .gate_a(gate_a),
    .gate_b(gate_b), .irq_clr(irq_clr), .irq_en(irq_en), .count(count),
    .running(running), .timer_flag(timer_flag), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_flag();
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    @(negedge clk);
  endtask

  // Called at a falling edge; returns at the falling edge after the start edge (k=0).
  task automatic do_start();
    start_now = 1'b1;
    @(negedge clk);
    start_now = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int rl [5] = '{0, 1, 2, 3, 5};
    int period, n, opened, cval;
    logic ga;

    rst_n = 1'b0; reload_val = '0; presc_val = '0; auto_restart = 0; auto_start_en = 0;
    gate_sel = 2'd0; start_now = 0; stop_now = 0; tx_end = 0; gate_a = 0; gate_b = 0;
    irq_clr = 0; irq_en = 0;
    repeat (3) @(negedge clk);
    check("R1 count", 32'(count), 0);
    check("R1 running", 32'(running), 0);
    check("R1 flag", 32'(timer_flag), 0);
    check("R1 irq", 32'(irq), 0);
    rst_n = 1'b1;
    irq_en = 1'b1;
    @(negedge clk);

    // Sweep prescaler and reload, no restart (R3, R4, R10; gate_sel 3 ungated R8)
    for (int p = 0; p < 4; p++) begin
      for (int ri = 0; ri < 5; ri++) begin
        presc_val = 12'(p);
        reload_val = 16'(rl[ri]);
        gate_sel = (p == 3) ? 2'd3 : 2'd0;
        clear_flag();
        do_start();
        period = 2 * p + 1;
        n = (rl[ri] == 0) ? period : rl[ri] * period;
        for (int k = 0; k <= n + 1; k++) begin
          check("R3 count", 32'(count), (k >= n) ? 0 : 32'(rl[ri] - k / period));
          check("R4 running", 32'(running), (k < n) ? 1 : 0);
          check("R10 irq", 32'(irq), (k >= n) ? 1 : 0);
          @(negedge clk);
        end
      end
    end
    gate_sel = 2'd0;

    // R2: restart while running
    presc_val = 12'd1; reload_val = 16'd5;
    clear_flag();
    do_start();
    repeat (4) @(negedge clk);
    check("R2 mid count", 32'(count), 4);
    do_start();
    check("R2 restart count", 32'(count), 5);
    check("R2 restart running", 32'(running), 1);
    @(negedge clk);
    @(negedge clk);

    // R6: stop and start together, stop wins, count holds
    cval = count;
    start_now = 1'b1; stop_now = 1'b1;
    @(negedge clk);
    start_now = 1'b0; stop_now = 1'b0;
    check("R6 running", 32'(running), 0);
    check("R6 count held", 32'(count), 32'(cval));
    repeat (5) @(negedge clk);
    check("R6 count still", 32'(count), 32'(cval));

    // R7: tx_end ignored without auto start, starts with it
    tx_end = 1'b1; @(negedge clk); tx_end = 1'b0;
    check("R7 ignored", 32'(running), 0);
    check("R7 ignored count", 32'(count), 32'(cval));
    auto_start_en = 1'b1; reload_val = 16'd9;
    tx_end = 1'b1; @(negedge clk); tx_end = 1'b0;
    check("R7 auto start", 32'(running), 1);
    check("R7 auto load", 32'(count), 9);
    tx_end = 1'b1; stop_now = 1'b1; @(negedge clk);
    tx_end = 1'b0; stop_now = 1'b0;
    check("R6 stop over tx", 32'(running), 0);
    auto_start_en = 1'b0;

    // R5: auto restart
    presc_val = 12'd0; reload_val = 16'd3; auto_restart = 1'b1;
    clear_flag();
    do_start();
    for (int k = 0; k < 10; k++) begin
      check("R5 count", 32'(count), 32'(3 - k % 3));
      check("R5 running", 32'(running), 1);
      check("R5 flag", 32'(timer_flag), (k >= 3) ? 1 : 0);
      @(negedge clk);
    end
    stop_now = 1'b1; @(negedge clk); stop_now = 1'b0;
    check("R6 stop restart mode", 32'(running), 0);
    auto_restart = 1'b0;

    // R8: gating by each pin, other pin toggles opposite
    for (int s = 1; s <= 2; s++) begin
      presc_val = 12'd1; reload_val = 16'd3; gate_sel = 2'(s);
      clear_flag();
      do_start();
      opened = 0;
      for (int k = 0; k < 40; k++) begin
        check("R8 count", 32'(count), (opened >= 9) ? 0 : 32'(3 - opened / 3));
        check("R8 running", 32'(running), (opened < 9) ? 1 : 0);
        ga = ((k * 7) % 5) < 2;
        gate_a = (s == 1) ? ga : ~ga;
        gate_b = (s == 1) ? ~ga : ga;
        if (ga) opened++;
        @(negedge clk);
      end
      gate_a = 0; gate_b = 0;
    end
    gate_sel = 2'd0;

    // R10: mask
    irq_en = 1'b0; #1;
    check("R10 masked irq", 32'(irq), 0);
    check("R9 flag kept", 32'(timer_flag), 1);
    irq_en = 1'b1; #1;
    check("R10 unmasked irq", 32'(irq), 1);
    @(negedge clk);

    // R9: clear, then set wins over clear
    clear_flag();
    check("R9 cleared", 32'(timer_flag), 0);
    presc_val = 12'd0; reload_val = 16'd1;
    do_start();
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    check("R9 set wins", 32'(timer_flag), 1);
    check("R4 zero reached", 32'(count), 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule